// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block is the sending half of a master-side synchronous serial port. Software writes up to four byte-wide data registers through a byte-enabled write port. When the transmitter is free, it moves a frame of 8, 16 or 32 bits from those registers into a shift register. It then drives an active-low chip select, a serial clock and a serial data line until every bit of the frame has left.

The mode inputs choose the frame length, the bit order, and the clock polarity and phase. The bit order decides which end of the data is sent first. It also decides the order of the byte registers: MSB-first walks upward from register 0, and LSB-first walks downward from the highest valid register. Two status flags report progress, and each flag raises a one-cycle interrupt request when it sets. The data-empty flag means the data registers may be written again. The end flag means the line went idle with no further data pending.

The state machine has three states:
- **IDLE**: chip select off.
- **LEAD**: the first half of a bit period.
- **TRAIL**: the second half of a bit period.

The state machine makes five transitions:
- **start**: IDLE to LEAD, when data is pending.
- **half**: LEAD to TRAIL, on a divider tick.
- **next**: TRAIL to LEAD, on a tick when bits remain.
- **reload**: TRAIL to LEAD, on a tick after the last bit when new data is pending.
- **finish**: TRAIL to IDLE, on a tick after the last bit when nothing is pending.

Top module: `sser_tx`

## Requirements
- R1: `len_sel` picks the frame length: 0 gives 8 bits from register 0, 1 gives 16 bits from registers 0 and 1, and 2 or 3 gives 32 bits from registers 0 to 3. Register i is written from `wr_data[8i+7:8i]` when `wr_be[i]` is 1, and a byte whose enable is 0 keeps its value.
- R2: With `msb_first`=1, bytes go out from register 0 up to the highest valid register, each byte from bit 7 down to bit 0.
- R3: With `msb_first`=0, bytes go out from the highest valid register down to register 0, each byte from bit 0 up to bit 7.
- R4: When a frame is loaded, `tdre` sets and `tx_irq` is high for exactly one cycle, in the first cycle with `cs_n` low.
- R5: After the last bit, if `tdre` is still set, the block returns to IDLE with `tend` set, and `end_irq` is high for exactly that first idle cycle.
- R6: `cs_n` stays low, without a gap, for exactly 2·HALF_PERIOD·(frame bits) cycles per frame.
- R7: With `cpol`=0 and `cpha`=0, `sclk` idles low and the first bit is on `sdo` from the first cycle of the frame. `sdo` changes only while `sclk` is low, so it is stable across every rising edge.
- R8: A write clears `tdre`. A frame starts only while `tdre` is clear and the block is in IDLE or ending a frame. A write made during a frame makes the next frame follow with `cs_n` held low.
- R9: Each level of `sclk` within a frame lasts exactly HALF_PERIOD system clocks.
- R10: `tend` clears when a frame starts, or when `end_clr` is pulsed.
- R11: `cpol`=1 makes `sclk` idle high. With `cpha`=1, data changes on the leading edge and is sampled on the trailing edge of each bit.
- R12: After reset, `cs_n`=1, `sclk`=`cpol`, `sdo`=1, `tdre`=1, `tend`=1 and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data register write strobe |
| wr_be | input | 4 | Byte enables, bit i selects register i |
| wr_data | input | 32 | Write data, byte i for register i |
| end_clr | input | 1 | Clears the end flag |
| len_sel | input | 2 | Frame length: 0 = 8, 1 = 16, 2/3 = 32 bits |
| msb_first | input | 1 | 1 = MSB-first order, 0 = LSB-first order |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| tdre | output | 1 | Data registers empty flag |
| tend | output | 1 | Transmission end flag |
| tx_irq | output | 1 | One-cycle pulse when `tdre` sets at a load |
| end_irq | output | 1 | One-cycle pulse when `tend` sets |

## Verification
The bench builds the block with HALF_PERIOD=2, so a full 32-bit frame takes only 128 cycles. This makes it possible to sweep every `len_sel` code in both bit orders over several data patterns, and to cover all four polarity and phase combinations. The short half period also keeps the back-to-back case and the byte-enable case within a short run. At this size, every expected bit, frame duration and flag edge can be computed in the bench from the byte values and the chosen mode.

// File: rtl/sser_pkg.sv
package sser_pkg;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 4;
    localparam int FRAME_W   = BYTE_W * MAX_BYTES;
    localparam int BIT_CW    = $clog2(FRAME_W);
    localparam int NB_W      = $clog2(MAX_BYTES + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } tx_state_t;
endpackage

// File: rtl/sser_halfdiv.sv
module sser_halfdiv #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sser_bytebank.sv
module sser_bytebank
    import sser_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [MAX_BYTES-1:0]   wr_be,
    input  logic [FRAME_W-1:0]     wr_data,
    output logic [FRAME_W-1:0]     word
);
    // Register 0 lands in the top byte of word, register MAX_BYTES-1 at the bottom.
    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_byte
        logic [BYTE_W-1:0] data_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '0;
            end else if (wr_en && wr_be[i]) begin
                data_q <= wr_data[i*BYTE_W +: BYTE_W];
            end
        end
        assign word[(MAX_BYTES-1-i)*BYTE_W +: BYTE_W] = data_q;
    end
endmodule

// File: rtl/sser_shreg.sv
module sser_shreg
    import sser_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic               msb_in,
    input  logic [NB_W-1:0]    nbytes,
    input  logic [FRAME_W-1:0] word,
    output logic               bit_out
);
    logic [FRAME_W-1:0] sh_q;
    logic               msb_q;
    int                 drop;

    // LSB-first sends the exact reverse of the MSB-first stream,
    // so the valid bytes are right-aligned and shifted out from bit 0.
    assign drop    = BYTE_W * (MAX_BYTES - int'(nbytes));
    assign bit_out = msb_q ? sh_q[FRAME_W-1] : sh_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            msb_q <= 1'b1;
        end else if (load) begin
            msb_q <= msb_in;
            sh_q  <= msb_in ? word : (word >> drop);
        end else if (shift) begin
            sh_q  <= msb_q ? (sh_q << 1) : (sh_q >> 1);
        end
    end
endmodule

// File: rtl/sser_tx.sv
module sser_tx
    import sser_pkg::*;
#(
    parameter int HALF_PERIOD = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [MAX_BYTES-1:0] wr_be,
    input  logic [FRAME_W-1:0]   wr_data,
    input  logic                 end_clr,
    input  logic [1:0]           len_sel,
    input  logic                 msb_first,
    input  logic                 cpol,
    input  logic                 cpha,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 sdo,
    output logic                 tdre,
    output logic                 tend,
    output logic                 tx_irq,
    output logic                 end_irq
);
    tx_state_t          state_q, state_n;
    logic               tick;
    logic               load_go, shift_go, end_go;
    logic               tdre_q, tend_q, tx_irq_q, end_irq_q;
    logic               cpol_q, cpha_q;
    logic [BIT_CW-1:0]  left_q;
    logic [NB_W-1:0]    nbytes;
    logic [FRAME_W-1:0] word;
    logic               bit_out;

    always_comb begin
        unique case (len_sel)
            2'd0:    nbytes = NB_W'(1);
            2'd1:    nbytes = NB_W'(2);
            default: nbytes = NB_W'(MAX_BYTES);
        endcase
    end

    sser_halfdiv #(.HALF(HALF_PERIOD)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    sser_bytebank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .word    (word)
    );

    sser_shreg u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_go),
        .shift   (shift_go),
        .msb_in  (msb_first),
        .nbytes  (nbytes),
        .word    (word),
        .bit_out (bit_out)
    );

    // Next state and transition strobes
    always_comb begin
        state_n  = state_q;
        load_go  = 1'b0;
        shift_go = 1'b0;
        end_go   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!tdre_q) begin           // start
                    load_go = 1'b1;
                    state_n = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) state_n = ST_TRAIL; // half
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (left_q != '0) begin   // next
                        shift_go = 1'b1;
                        state_n  = ST_LEAD;
                    end else if (!tdre_q) begin // reload
                        load_go = 1'b1;
                        state_n = ST_LEAD;
                    end else begin            // finish
                        end_go  = 1'b1;
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Frame bookkeeping, flags and request pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q    <= '0;
            tdre_q    <= 1'b1;
            tend_q    <= 1'b1;
            tx_irq_q  <= 1'b0;
            end_irq_q <= 1'b0;
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
        end else begin
            tx_irq_q  <= load_go;
            end_irq_q <= end_go;
            if (load_go) begin
                left_q <= BIT_CW'(int'(nbytes) * BYTE_W - 1);
                cpol_q <= cpol;
                cpha_q <= cpha;
            end else if (shift_go) begin
                left_q <= left_q - 1'b1;
            end
            if (wr_en)        tdre_q <= 1'b0;
            else if (load_go) tdre_q <= 1'b1;
            if (end_go)                 tend_q <= 1'b1;
            else if (load_go || end_clr) tend_q <= 1'b0;
        end
    end

    // Outputs decoded from the registered state
    always_comb begin
        tdre    = tdre_q;
        tend    = tend_q;
        tx_irq  = tx_irq_q;
        end_irq = end_irq_q;
        unique case (state_q)
            ST_LEAD: begin
                cs_n = 1'b0;
                sclk = cpol_q ^ cpha_q;
                sdo  = bit_out;
            end
            ST_TRAIL: begin
                cs_n = 1'b0;
                sclk = cpol_q ^ ~cpha_q;
                sdo  = bit_out;
            end
            default: begin
                cs_n = 1'b1;
                sclk = cpol;
                sdo  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sser_tx_chk.sv
module sser_tx_chk #(
    parameter int HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cpol,
    input logic cpha,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic tdre,
    input logic tend,
    input logic tx_irq,
    input logic end_irq
);
    logic [15:0] run_q;
    logic        sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 16'd1;
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (sclk != sclk_q)     run_q <= 16'd1;
            else if (run_q != '1)   run_q <= run_q + 1'b1;
        end
    end

    assert_idle_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cpol));

    assert_txi_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tdre && !cs_n));

    assert_txi_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    assert_end_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> (tend && cs_n));

    assert_end_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend) |-> end_irq);

    assert_start_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> tx_irq);

    assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && sclk && $past(sclk) && !cpol && !cpha) |-> $stable(sdo));

    assert_half_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (sclk == cpol) && (sclk_q != cpol)) |-> (run_q == 16'(HALF)));
endmodule

bind sser_tx sser_tx_chk #(.HALF(HALF_PERIOD)) u_sser_tx_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpol    (cpol),
    .cpha    (cpha),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sdo     (sdo),
    .tdre    (tdre),
    .tend    (tend),
    .tx_irq  (tx_irq),
    .end_irq (end_irq)
);

// File: tb/test_sser_tx.sv
module test_sser_tx;
    localparam int HP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = '0;
    logic        end_clr = 1'b0;
    logic [1:0]  len_sel = 2'd0;
    logic        msb_first = 1'b1;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        cs_n, sclk, sdo, tdre, tend, tx_irq, end_irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sser_tx #(.HALF_PERIOD(HP)) i_sser_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .end_clr(end_clr), .len_sel(len_sel), .msb_first(msb_first), .cpol(cpol),
        .cpha(cpha), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .tdre(tdre), .tend(tend),
        .tx_irq(tx_irq), .end_irq(end_irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int nbytes_of(input logic [1:0] ls);
        return (ls == 2'd0) ? 1 : (ls == 2'd1) ? 2 : 4;
    endfunction

    // Bit i of the stream: register b holds data[8b+7:8b]
    function automatic logic exp_bit(input logic [31:0] d, input int nb, input logic m, input int i);
        int b;
        int k;
        if (m) begin
            b = i / 8;
            k = 7 - (i % 8);
        end else begin
            b = nb - 1 - i / 8;
            k = i % 8;
        end
        return d[8*b + k];
    endfunction

    task automatic do_frame(input logic [1:0] ls, input logic m, input logic cp, input logic ch,
                            input logic [3:0] be, input logic [31:0] wd, input logic [31:0] ed,
                            input string tag);
        int nb, total, cyc, nbits, bad;
        logic prev_s;
        nb = nbytes_of(ls);
        total = 8 * nb;
        len_sel = ls; msb_first = m; cpol = cp; cpha = ch;
        wr_en = 1'b1; wr_be = be; wr_data = wd;
        @(negedge clk);
        wr_en = 1'b0;
        chk(tdre == 1'b0 && cs_n == 1'b1, "R8 write clears tdre", tdre, 0);
        @(negedge clk);
        chk(cs_n == 1'b0 && tx_irq && tdre, {"R4 load pulse ", tag}, {cs_n, tx_irq, tdre}, 3);
        chk(tend == 1'b0, "R10 start clears tend", tend, 0);
        if (!ch) chk(sdo == exp_bit(ed, nb, m, 0), {"R7 first bit early ", tag}, sdo, exp_bit(ed, nb, m, 0));
        cyc = 0; nbits = 0; bad = 0; prev_s = cp;
        while (!cs_n && cyc < 1000) begin
            if (cyc == 1) chk(!tx_irq, "R4 single pulse", tx_irq, 0);
            if (sclk != prev_s) begin
                if ((sclk != cp) == !ch) begin
                    if (nbits < 64 && sdo != exp_bit(ed, nb, m, nbits)) bad++;
                    nbits++;
                end
            end
            prev_s = sclk;
            cyc++;
            @(negedge clk);
        end
        chk(bad == 0, m ? {"R2 order ", tag} : {"R3 order ", tag}, bad, 0);
        chk(nbits == total, {"R1 bit count ", tag}, nbits, total);
        chk(cyc == total * 2 * HP, {"R6 R9 frame cycles ", tag}, cyc, total * 2 * HP);
        chk(end_irq && tend, {"R5 end flag ", tag}, {end_irq, tend}, 3);
        chk(sclk == cp, {"R11 idle level ", tag}, sclk, cp);
        @(negedge clk);
        chk(!end_irq, "R5 end pulse one cycle", end_irq, 0);
    endtask

    initial begin
        logic [31:0] pat;
        logic [31:0] da, db;
        int total, cyc, nbits, bad, npulse, nend;
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && sdo && tdre && tend && !tx_irq && !end_irq,
            "R12 reset state", {cs_n, sclk, sdo, tdre, tend, tx_irq, end_irq}, 7'b1011100);
        rst_n = 1'b1;
        @(negedge clk);
        repeat (10) @(negedge clk);
        chk(cs_n, "R8 no start while tdre set", cs_n, 1);

        // Sweep lengths, orders and patterns in mode 0/0
        for (int ls = 0; ls < 4; ls++) begin
            for (int m = 0; m < 2; m++) begin
                for (int p = 0; p < 3; p++) begin
                    pat = (p == 0) ? 32'hA5C3_0F81 :
                          (p == 1) ? (32'h1 << (ls * 7 + m * 3 + 1)) :
                          (32'h1357_9BDF ^ (32'h0101_0101 * (ls + 1)));
                    do_frame(2'(ls), m[0], 1'b0, 1'b0, 4'hF, pat, pat, "mode00");
                end
            end
        end

        // Polarity and phase combinations
        for (int c = 1; c < 4; c++) begin
            for (int m = 0; m < 2; m++) begin
                do_frame(2'd1, m[0], c[1], c[0], 4'hF, 32'h00C6_39E1, 32'h00C6_39E1, "R11 mode");
            end
        end
        cpol = 1'b0; cpha = 1'b0;
        @(negedge clk);

        // Byte enables: only register 0 changes
        do_frame(2'd1, 1'b1, 1'b0, 1'b0, 4'hF, 32'h0000_5A3C, 32'h0000_5A3C, "R1 prime");
        do_frame(2'd1, 1'b1, 1'b0, 1'b0, 4'h1, 32'hFFFF_FF81, 32'h0000_5A81, "R1 byte enable");

        // Software clear of the end flag
        end_clr = 1'b1;
        @(negedge clk);
        end_clr = 1'b0;
        chk(!tend, "R10 end_clr clears tend", tend, 0);

        // Back-to-back frames: second write arrives mid-frame
        da = 32'h0000_00B4; db = 32'h0000_0067;
        len_sel = 2'd0; msb_first = 1'b1;
        total = 8;
        wr_en = 1'b1; wr_be = 4'hF; wr_data = da;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        cyc = 0; nbits = 0; bad = 0; npulse = 0; nend = 0;
        while (!cs_n && cyc < 1000) begin
            if (tx_irq) npulse++;
            if (end_irq) nend++;
            if (cyc == 5) begin wr_en = 1'b1; wr_data = db; end
            if (cyc == 6) wr_en = 1'b0;
            if (sclk && (cyc % (2 * HP)) == HP) begin
                if (sdo != ((nbits < 8) ? da[7 - nbits] : db[15 - nbits])) bad++;
                nbits++;
            end
            cyc++;
            @(negedge clk);
        end
        chk(cyc == 2 * total * 2 * HP, "R8 back-to-back no gap", cyc, 2 * total * 2 * HP);
        chk(bad == 0 && nbits == 16, "R2 back-to-back data", bad, 0);
        chk(npulse == 2 && nend == 0, "R4 R5 back-to-back flags", npulse * 10 + nend, 20);
        chk(end_irq && tend, "R5 end after second frame", {end_irq, tend}, 3);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule